// File: doc/BRIEF.md
# Bit-Serial Symmetric FIR Filter Without Multipliers

This block is a 32-tap low-pass FIR filter whose coefficients are fixed and even-symmetric. It contains no multiplier. Each accepted 12-bit signed sample enters a delay line. The two taps of every mirrored pair are summed into a 13-bit word, which gives sixteen words. The block then walks through those words one bit column per clock, starting at the least significant bit.

Each 16-bit column addresses a set of precomputed coefficient-sum tables. The table output is weighted by the column's bit position and accumulated. For the final column, which holds the two's-complement sign, the weighted value is subtracted instead of added.

A producer offers samples with a strobe. A sample is taken only when the previous pass has ended; a strobe seen during a pass is dropped. When the pass finishes, the block raises a one-clock result strobe together with a 32-bit signed result.

Top module: `da_fir_serial`

## Requirements
- R1: The impulse response has 32 taps and is even-symmetric: the tap k weight equals the tap 31-k weight.
- R2: The weights of taps 0 to 15 are 4, 9, 13, 12, 5, -10, -30, -48, -55, -39, 3, 72, 158, 247, 321, 362. Each result equals the sum over k of weight(k) times the sample accepted k samples earlier. Tap 0 is the newest sample.
- R3: Input samples are 12-bit two's complement. The 32-bit signed result is exact for every input, including a long run of -2048 or +2047, and the accumulator never overflows.
- R4: The result strobe rises 18 clock edges after the edge that accepts a sample.
- R5: The result strobe lasts exactly one cycle per accepted sample. The result value holds until the next result.
- R6: A sample strobe that arrives while a pass is in progress is ignored: it changes neither the delay line nor any later result.
- R7: After reset the result is 0, the result strobe is low and the delay line holds zeros.
- R8: The sign column's weighted table value is subtracted from the running sum. Sums with a negative pre-added word are therefore exact.
- R9: Bit columns are processed least significant first, with index 0 to 12. Each pass processes exactly 13 columns, and the index increases by one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample offer strobe |
| smp_i | input | 12 | Signed input sample |
| res_vld_o | output | 1 | One-cycle result strobe |
| res_o | output | 32 | Signed filter result |

## Verification
A fault in the delay line or the pre-adders shows up as a wrong result as soon as the affected tap holds a nonzero sample, at most 32 samples after the fault. An impulse sweep exposes it tap by tap. A wrong column order, a wrong shift or a missing subtract on the sign column corrupts the very next result: every output is computed exactly from the 13 columns of that pass. A control fault in the busy window shows up within one pass, either as a latency that is not 18, a strobe longer than one cycle, or a history shifted by an accepted stray sample.

// File: rtl/da_fir_pkg.sv
`timescale 1ns/1ps
package da_fir_pkg;
  localparam int TAPS = 32;
  localparam int HALF = TAPS / 2;

  // weight of tap k, folded onto the lower half of the symmetric response
  function automatic int coef(input int k);
    int m;
    m = (k < HALF) ? k : (TAPS - 1 - k);
    case (m)
      0: coef = 4;     1: coef = 9;     2: coef = 13;    3: coef = 12;
      4: coef = 5;     5: coef = -10;   6: coef = -30;   7: coef = -48;
      8: coef = -55;   9: coef = -39;   10: coef = 3;    11: coef = 72;
      12: coef = 158;  13: coef = 247;  14: coef = 321;  default: coef = 362;
    endcase
  endfunction

  // one entry of a partition table: sum of the weights whose address bit is set
  function automatic int tbl_entry(input int base, input int addr, input int gsz);
    int s;
    s = 0;
    for (int j = 0; j < gsz; j++)
      if (((addr >> j) & 1) == 1) s += coef(base + j);
    return s;
  endfunction
endpackage

// File: rtl/da_fir_taps.sv
`timescale 1ns/1ps
module da_fir_taps #(
  parameter int DW   = 12,
  parameter int TAPS = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         shift_i,
  input  logic [DW-1:0]                smp_i,
  output logic [DW-1:0]                newest_o,
  output logic [TAPS/2-1:0][DW:0]      pre_o
);
  localparam int HALF = TAPS / 2;

  logic [TAPS-1:0][DW-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else if (shift_i) line_q <= {line_q[TAPS-2:0], smp_i};
  end

  assign newest_o = line_q[0];

  // mirrored pair pre-add, sign-extended by one bit
  generate
    for (genvar i = 0; i < HALF; i++) begin : g_pair
      assign pre_o[i] = {line_q[i][DW-1], line_q[i]} +
                        {line_q[TAPS-1-i][DW-1], line_q[TAPS-1-i]};
    end
  endgenerate
endmodule

// File: rtl/da_fir_slicer.sv
`timescale 1ns/1ps
module da_fir_slicer #(
  parameter int N  = 16,
  parameter int PW = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 shift_i,
  input  logic [N-1:0][PW-1:0] words_i,
  output logic [N-1:0]         slice_o
);
  logic [N-1:0][PW-1:0] w_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) w_q <= '0;
    else if (load_i) w_q <= words_i;
    else if (shift_i) begin
      for (int i = 0; i < N; i++) w_q[i] <= {1'b0, w_q[i][PW-1:1]};
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_col
      assign slice_o[i] = w_q[i][0];
    end
  endgenerate
endmodule

// File: rtl/da_fir_coef_rom.sv
`timescale 1ns/1ps
module da_fir_coef_rom
  import da_fir_pkg::*;
#(
  parameter int HALF_N = 16,
  parameter int GRP    = 4,
  parameter int TW     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HALF_N-1:0]    slice_i,
  output logic signed [TW-1:0] sum_o
);
  localparam int NG  = HALF_N / GRP;
  localparam int ENT = 1 << GRP;

  logic [NG-1:0][TW-1:0] part_w;
  logic signed [TW-1:0]  total_w;

  generate
    for (genvar g = 0; g < NG; g++) begin : g_part
      logic signed [TW-1:0] tbl [ENT];
      logic signed [TW-1:0] part_q;
      always_comb begin
        for (int a = 0; a < ENT; a++) tbl[a] = TW'(tbl_entry(g * GRP, a, GRP));
      end
      // first register level after the lookup
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) part_q <= '0;
        else part_q <= tbl[slice_i[g*GRP +: GRP]];
      end
      assign part_w[g] = part_q;
    end
  endgenerate

  always_comb begin
    total_w = '0;
    for (int g = 0; g < NG; g++) total_w = total_w + $signed(part_w[g]);
  end

  // second register level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_o <= '0;
    else sum_o <= total_w;
  end
endmodule

// File: rtl/da_fir_serial.sv
`timescale 1ns/1ps
module da_fir_serial
  import da_fir_pkg::*;
#(
  parameter int DW   = 12,
  parameter int GRP  = 4,
  parameter int TW   = 16,
  parameter int ACCW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_vld_i,
  input  logic [DW-1:0]          smp_i,
  output logic                   res_vld_o,
  output logic signed [ACCW-1:0] res_o
);
  localparam int PW   = DW + 1;
  localparam int CNTW = $clog2(PW);
  localparam logic [CNTW-1:0] LASTIDX = CNTW'(PW - 1);

  function automatic logic signed [ACCW-1:0] weigh(input logic signed [TW-1:0] v,
                                                   input logic [CNTW-1:0] s);
    logic signed [ACCW-1:0] e;
    e = ACCW'(v);
    return e <<< s;
  endfunction

  // control
  logic            busy_q, load_q, run_q;
  logic [CNTW-1:0] cnt_q;
  logic            accept_w;
  assign accept_w = smp_vld_i && !busy_q;

  logic [HALF-1:0][PW-1:0] pre_w;
  logic [DW-1:0]           newest_w;
  logic [HALF-1:0]         slice_w;

  da_fir_taps #(.DW(DW), .TAPS(TAPS)) u_taps (
    .clk(clk), .rst_n(rst_n), .shift_i(accept_w), .smp_i(smp_i),
    .newest_o(newest_w), .pre_o(pre_w));

  da_fir_slicer #(.N(HALF), .PW(PW)) u_slc (
    .clk(clk), .rst_n(rst_n), .load_i(load_q), .shift_i(run_q),
    .words_i(pre_w), .slice_o(slice_w));

  // stage A: column capture with its tags
  logic            a_vld, a_first, a_last;
  logic [CNTW-1:0] a_idx;
  logic [HALF-1:0] a_slice;
  // tags following the two table registers
  logic            b_vld, b_first, b_last, c_vld, c_first, c_last;
  logic [CNTW-1:0] b_idx, c_idx;
  logic signed [TW-1:0] c_sum;
  // stage D: weighted term
  logic            d_vld, d_first, d_last;
  logic signed [ACCW-1:0] d_term;

  logic signed [ACCW-1:0] acc_q;
  logic signed [ACCW:0]   acc_base_w, acc_next_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; load_q <= 1'b0; run_q <= 1'b0; cnt_q <= '0;
    end else begin
      load_q <= accept_w;
      if (accept_w) busy_q <= 1'b1;
      else if (d_vld && d_last) busy_q <= 1'b0;
      if (load_q) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LASTIDX) run_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld <= 1'b0; a_first <= 1'b0; a_last <= 1'b0; a_idx <= '0; a_slice <= '0;
    end else begin
      a_vld   <= run_q;
      a_first <= run_q && (cnt_q == '0);
      a_last  <= run_q && (cnt_q == LASTIDX);
      a_idx   <= cnt_q;
      a_slice <= run_q ? slice_w : '0;
    end
  end

  da_fir_coef_rom #(.HALF_N(HALF), .GRP(GRP), .TW(TW)) u_rom (
    .clk(clk), .rst_n(rst_n), .slice_i(a_slice), .sum_o(c_sum));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_vld <= 1'b0; b_first <= 1'b0; b_last <= 1'b0; b_idx <= '0;
      c_vld <= 1'b0; c_first <= 1'b0; c_last <= 1'b0; c_idx <= '0;
      d_vld <= 1'b0; d_first <= 1'b0; d_last <= 1'b0; d_term <= '0;
    end else begin
      b_vld <= a_vld; b_first <= a_first; b_last <= a_last; b_idx <= a_idx;
      c_vld <= b_vld; c_first <= b_first; c_last <= b_last; c_idx <= b_idx;
      d_vld <= c_vld; d_first <= c_first; d_last <= c_last;
      d_term <= weigh(c_sum, c_idx);
    end
  end

  // accumulate; the sign column is subtracted
  always_comb begin
    acc_base_w = d_first ? '0 : {acc_q[ACCW-1], acc_q};
    if (d_last) acc_next_w = acc_base_w - {d_term[ACCW-1], d_term};
    else        acc_next_w = acc_base_w + {d_term[ACCW-1], d_term};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; res_o <= '0; res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= d_vld && d_last;
      if (d_vld) acc_q <= acc_next_w[ACCW-1:0];
      if (d_vld && d_last) res_o <= acc_next_w[ACCW-1:0];
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_vld |-> (acc_next_w[ACCW] == acc_next_w[ACCW-1]));
  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |=> !res_vld_o);
  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && busy_q) |=> $stable(newest_w));
  // R8
  sign_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld && d_last) |=> res_vld_o);
  // R9
  col_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_vld && a_first) |-> (a_idx == '0));
  // R9
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_vld && !a_last) |=> (a_vld && (a_idx == $past(a_idx) + 1'b1)));
  // R9
  col_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_vld && a_last) |-> (a_idx == LASTIDX));
endmodule

// File: tb/sim_da_fir_serial.sv
`timescale 1ns/1ps
module sim_da_fir_serial;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic [11:0] smp = '0;
  logic res_vld;
  logic signed [31:0] res;

  int n_chk = 0;
  int n_bad = 0;
  int hist [32];
  int lfsr = 32'h1ACE;
  bit done = 1'b0;

  always #2 clk = ~clk;

  da_fir_serial u0 (.clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld), .smp_i(smp),
                    .res_vld_o(res_vld), .res_o(res));

  function automatic int wlo(input int k);
    int t [16] = '{4, 9, 13, 12, 5, -10, -30, -48, -55, -39, 3, 72, 158, 247, 321, 362};
    return t[k];
  endfunction

  // R1: mirrored weight lookup
  function automatic int wt(input int k);
    return (k > 15) ? wlo(31 - k) : wlo(k);
  endfunction

  function automatic int expect_y();
    int s = 0;
    for (int k = 0; k < 32; k++) s += wt(k) * hist[k];
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // offer one sample; optionally fire a stray strobe mid-pass
  task automatic send(input int v, input string req, input bit stray);
    int lat = 0;
    int yv;
    @(negedge clk);
    smp_vld = 1'b1;
    smp = v[11:0];
    @(posedge clk);
    for (int k = 31; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v;
    @(negedge clk);
    smp_vld = 1'b0;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (stray && lat == 4) begin smp_vld = 1'b1; smp = 12'h5A5; end
      else smp_vld = 1'b0;
      if (res_vld || lat > 60) break;
    end
    smp_vld = 1'b0;
    chk(lat == 18, "R4", lat, 18);
    chk(res == expect_y(), req, res, expect_y());
    yv = res;
    @(negedge clk);
    chk(!res_vld && res == yv, "R5", res_vld, 0);
  endtask

  initial begin
    for (int k = 0; k < 32; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(res_vld == 1'b0, "R7", res_vld, 0);
    chk(res == 0, "R7", res, 0);
    rst_n = 1'b1;
    // R1 R2 R7: unit impulse walks through every tap weight
    send(1, "R7", 1'b0);
    for (int i = 1; i < 32; i++) send(0, "R1", 1'b0);
    // R8: most negative impulse, negative pre-added words
    send(-2048, "R8", 1'b0);
    for (int i = 1; i < 32; i++) send(0, "R8", 1'b0);
    // R3: full-scale runs of both signs and a sign-chasing pattern
    for (int i = 0; i < 40; i++) send(2047, "R3", 1'b0);
    for (int i = 0; i < 40; i++) send(-2048, "R3", 1'b0);
    for (int i = 0; i < 40; i++) send((wt(i % 32) < 0) ? -2048 : 2047, "R3", 1'b0);
    // R2 R6: pseudo-random samples, stray strobes during some passes
    for (int i = 0; i < 300; i++) begin
      lfsr = lfsr ^ (lfsr << 7);
      lfsr = lfsr ^ (lfsr >>> 9);
      lfsr = lfsr & 32'h7FFF_FFFF;
      send((lfsr % 4096) - 2048, (i % 3 == 0) ? "R6" : "R2", i % 3 == 0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule